// File: doc/BRIEF.md
# Multi-Mode Program Bank Mapper

This block turns a CPU address in the upper 40 KB of a 64 KB space into a program ROM location. The location is given as an 8 KB bank number plus a 13-bit offset. Software sets four 8-bit bank registers and two control registers through write strobes. The first control register picks one of eight layouts for the 32 KB area at $8000–$FFFF: one 32 KB page, two 16 KB pages or four 8 KB pages. The layout also decides whether the highest page is pinned to the last bank or taken from bank register 3. The same control register can open an extra 8 KB ROM window at $6000–$7FFF.

A second control register supplies a 2-bit outer bank field. This field sits above every bank number the block produces, so a 256-bank ROM can be reached. Translation is purely combinational. A register written on one clock edge governs every access presented after that edge. The surrounding bus logic uses `rom_en` to decide whether the ROM answers the current address.

Top module: `prg_bank_mapper`

## Requirements
- R1: After synchronous reset, all bank registers hold 0xFF and both control registers hold 0. This gives layout 0, outer field 0 and the window closed, so $8000/$A000/$C000/$E000 map to 8 KB banks 0x3C/0x3D/0x3E/0x3F.
- R2: A write with `bank_we` high stores `wr_data` into bank register `wr_sel`. A write with `ctrl_we` high stores into control register 0 when `wr_sel`=0 and into control register 3 when `wr_sel`=3. Control writes with `wr_sel` 1 or 2 change nothing.
- R3: Control register 0 bits 2:0 form the layout code. Codes 0 and 4 map one 32 KB page: fixed 32 KB bank 0x0F for code 0, or bank register 3 bits 3:0 for code 4. The 8 KB bank is {page, address bits 14:13}.
- R4: Codes 1 and 5 map 16 KB pages. $8000–$BFFF uses bank register 1 bits 4:0. $C000–$FFFF uses fixed 0x1F for code 1, or bank register 3 bits 4:0 for code 5. The 8 KB bank is {page, address bit 13}.
- R5: Codes 2, 3, 6 and 7 map 8 KB pages. $8000, $A000 and $C000 use bank registers 0, 1 and 2, bits 5:0. $E000 uses fixed 0x3F for codes 2 and 3, or bank register 3 bits 5:0 for codes 6 and 7.
- R6: Control register 3 bits 2:1 appear as `rom_bank` bits 7:6 for every ROM access. All other bits of control register 3 have no effect.
- R7: Control register 0 bit 7 opens the window at $6000–$7FFF. The window's 8 KB bank (bits 5:0) is (reg3×4+3) mod 64 for codes 0 and 4, (reg3×2+1) mod 64 for codes 1 and 5, and reg3 mod 64 for the 8 KB codes.
- R8: `rom_en` is low and `rom_bank` is 0 for addresses below $6000. The same holds for $6000–$7FFF while the window is closed.
- R9: `rom_offset` always equals address bits 12:0.
- R10: Translation is combinational. A change of `cpu_addr` shows on the outputs in the same cycle. With no write and a steady address, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_we | input | 1 | Bank register write strobe |
| ctrl_we | input | 1 | Control register write strobe |
| wr_sel | input | 2 | Register index of the write |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_bank | output | 8 | ROM 8 KB bank number, outer field on top |
| rom_offset | output | 13 | Byte offset inside the 8 KB bank |
| rom_en | output | 1 | Address maps to ROM |

## Verification
The bench builds the block with its default parameters: 8-bit registers, a 16-bit address, 6-bit 8 KB bank numbers and a 2-bit outer field. This brings all eight layout codes within reach, along with the all-ones fixed banks at every granularity and all four outer values. It also reaches the modulo-64 wrap of the window arithmetic when bank register 3 is 0xFF. Checks cover each address quarter in each layout, writes that must not count, and the closed and open window.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int MODE_W      = 3;
  localparam int WIN_EN_BIT  = 7;
  localparam int OUTER_LSB   = 1;

  typedef enum logic [1:0] {
    GRAN_32K = 2'd0,
    GRAN_16K = 2'd1,
    GRAN_8K  = 2'd2
  } gran_e;

  // Low two bits of the layout code give the page size.
  function automatic gran_e gran_of(input logic [MODE_W-1:0] mode);
    case (mode[1:0])
      2'b00:   return GRAN_32K;
      2'b01:   return GRAN_16K;
      default: return GRAN_8K;
    endcase
  endfunction

  // High bit of the layout code: top page comes from bank register 3.
  function automatic logic top_from_reg(input logic [MODE_W-1:0] mode);
    return mode[2];
  endfunction

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
  import prg_map_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int OUTER_W  = 2,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bank_we,
  input  logic                              ctrl_we,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   bank_q,
  output logic [MODE_W-1:0]                 mode,
  output logic                              win_en,
  output logic [OUTER_W-1:0]                outer
);

  localparam logic [SEL_W-1:0] SEL_MAIN  = '0;
  localparam logic [SEL_W-1:0] SEL_OUTER = SEL_W'(NUM_REGS - 1);

  logic [DATA_W-1:0] ctrl_main_q;
  logic [DATA_W-1:0] ctrl_outer_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank_q[i] <= '1;
    end else if (bank_we) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_sel == SEL_W'(i)) bank_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_main_q  <= '0;
      ctrl_outer_q <= '0;
    end else if (ctrl_we) begin
      if (wr_sel == SEL_MAIN)  ctrl_main_q  <= wr_data;
      if (wr_sel == SEL_OUTER) ctrl_outer_q <= wr_data;
    end
  end

  assign mode   = ctrl_main_q[MODE_W-1:0];
  assign win_en = ctrl_main_q[WIN_EN_BIT];
  assign outer  = ctrl_outer_q[OUTER_LSB +: OUTER_W];

endmodule

// File: rtl/prg_map_slot.sv
module prg_map_slot
  import prg_map_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int BANK_W   = 6,
  parameter int SLOT     = 0
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q,
  input  logic [MODE_W-1:0]               mode,
  output logic [BANK_W-1:0]               slot_bank
);

  localparam int B16_W = BANK_W - 1;
  localparam int B32_W = BANK_W - 2;
  localparam int LAST  = NUM_REGS - 1;
  localparam int SLOTS = 4;
  localparam logic [1:0] QUARTER = 2'(SLOT);
  localparam int HALF_REG = (SLOT < SLOTS / 2) ? 1 : LAST;
  localparam int EIGHTH_REG = (SLOT < SLOTS - 1) ? SLOT : LAST;

  logic [B32_W-1:0] page32;
  logic [B16_W-1:0] page16;
  logic [BANK_W-1:0] page8;
  logic reg_top;

  assign reg_top = top_from_reg(mode);

  assign page32 = reg_top ? bank_q[LAST][B32_W-1:0] : '1;

  generate
    if (SLOT < SLOTS / 2) begin : g_low_half
      assign page16 = bank_q[HALF_REG][B16_W-1:0];
    end else begin : g_high_half
      assign page16 = reg_top ? bank_q[HALF_REG][B16_W-1:0] : '1;
    end

    if (SLOT < SLOTS - 1) begin : g_free_eighth
      assign page8 = bank_q[EIGHTH_REG][BANK_W-1:0];
    end else begin : g_top_eighth
      assign page8 = reg_top ? bank_q[EIGHTH_REG][BANK_W-1:0] : '1;
    end
  endgenerate

  always_comb begin
    case (gran_of(mode))
      GRAN_32K: slot_bank = {page32, QUARTER};
      GRAN_16K: slot_bank = {page16, QUARTER[0]};
      default:  slot_bank = page8;
    endcase
  end

endmodule

// File: rtl/prg_map_window.sv
module prg_map_window
  import prg_map_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 6
) (
  input  logic [DATA_W-1:0] src,
  input  logic [MODE_W-1:0] mode,
  output logic [BANK_W-1:0] win_bank
);

  always_comb begin
    case (gran_of(mode))
      GRAN_32K: win_bank = {src[BANK_W-3:0], 2'b11};
      GRAN_16K: win_bank = {src[BANK_W-2:0], 1'b1};
      default:  win_bank = src[BANK_W-1:0];
    endcase
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int BANK_W   = 6,
  parameter int OUTER_W  = 2,
  parameter int PAGE_W   = 13,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int OUT_W   = OUTER_W + BANK_W,
  localparam int SLOTS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_we,
  input  logic              ctrl_we,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [OUT_W-1:0]  rom_bank,
  output logic [PAGE_W-1:0] rom_offset,
  output logic              rom_en
);

  localparam logic [2:0] WIN_REGION = 3'b011;

  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
  logic [MODE_W-1:0]               mode;
  logic                            win_en;
  logic [OUTER_W-1:0]              outer;
  logic [SLOTS-1:0][BANK_W-1:0]    slot_bank;
  logic [BANK_W-1:0]               win_bank;
  logic [2:0]                      region;
  logic                            in_rom;
  logic                            in_win;

  prg_map_regs #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .OUTER_W(OUTER_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bank_we(bank_we), .ctrl_we(ctrl_we),
    .wr_sel(wr_sel), .wr_data(wr_data), .bank_q(bank_q),
    .mode(mode), .win_en(win_en), .outer(outer)
  );

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      prg_map_slot #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BANK_W(BANK_W), .SLOT(s)
      ) u_slot (
        .bank_q(bank_q), .mode(mode), .slot_bank(slot_bank[s])
      );
    end
  endgenerate

  prg_map_window #(
    .DATA_W(DATA_W), .BANK_W(BANK_W)
  ) u_win (
    .src(bank_q[NUM_REGS-1]), .mode(mode), .win_bank(win_bank)
  );

  assign region = cpu_addr[ADDR_W-1 -: 3];
  assign in_rom = cpu_addr[ADDR_W-1];
  assign in_win = (region == WIN_REGION) && win_en;

  always_comb begin
    rom_en   = in_rom || in_win;
    rom_bank = '0;
    if (in_rom)
      rom_bank = {outer, slot_bank[cpu_addr[PAGE_W +: 2]]};
    else if (in_win)
      rom_bank = {outer, win_bank};
  end

  assign rom_offset = cpu_addr[PAGE_W-1:0];

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int SEL_W   = 2,
  parameter int BANK_W  = 6,
  parameter int OUTER_W = 2,
  parameter int PAGE_W  = 13
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bank_we,
  input logic                        ctrl_we,
  input logic [SEL_W-1:0]            wr_sel,
  input logic [DATA_W-1:0]           wr_data,
  input logic [ADDR_W-1:0]           cpu_addr,
  input logic [OUTER_W+BANK_W-1:0]   rom_bank,
  input logic [PAGE_W-1:0]           rom_offset,
  input logic                        rom_en
);

  localparam int OUT_W = OUTER_W + BANK_W;

  logic live;
  logic rst_seen;

  always_ff @(posedge clk) begin
    live <= !rst;
    if (rst) rst_seen <= 1'b1;
  end

  // R1: first cycle out of reset shows fixed 32 KB page 0x0F, outer 0
  a_r1_reset_layout: assert property (@(posedge clk) disable iff (rst)
    (rst_seen === 1'b1) && $fell(rst) && cpu_addr[ADDR_W-1] |->
      rom_bank[OUT_W-1:BANK_W] == '0 && rom_bank[BANK_W-1:2] == '1 &&
      rom_bank[1:0] == cpu_addr[PAGE_W +: 2]);

  // R8: nothing below the window region reaches the ROM
  a_r8_low_unmapped: assert property (@(posedge clk) disable iff (rst)
    cpu_addr[ADDR_W-1 -: 3] < 3'b011 |-> !rom_en && rom_bank == '0);

  // R6: outer field written to control register 3 leads every ROM bank
  a_r6_outer_field: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && wr_sel == SEL_W'(3) |=>
      !rom_en || rom_bank[OUT_W-1:BANK_W] == $past(wr_data[1 +: OUTER_W]));

  // R7: clearing the window bit closes $6000-$7FFF
  a_r7_window_closed: assert property (@(posedge clk) disable iff (rst)
    ctrl_we && wr_sel == '0 && !wr_data[DATA_W-1] |=>
      cpu_addr[ADDR_W-1 -: 3] != 3'b011 || !rom_en);

  // R10: no write and a steady address keep the outputs steady
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    live && !$past(bank_we) && !$past(ctrl_we) && $stable(cpu_addr) |->
      $stable(rom_bank) && $stable(rom_en) && $stable(rom_offset));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
  .BANK_W(BANK_W), .OUTER_W(OUTER_W), .PAGE_W(PAGE_W)
) u_chk (.*);

// File: tb/prg_bank_mapper_test.sv
module prg_bank_mapper_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        bank_we;
  logic        ctrl_we;
  logic [1:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [15:0] cpu_addr;
  logic [7:0]  rom_bank;
  logic [12:0] rom_offset;
  logic        rom_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_bank_mapper uut (
    .clk(clk), .rst(rst), .bank_we(bank_we), .ctrl_we(ctrl_we),
    .wr_sel(wr_sel), .wr_data(wr_data), .cpu_addr(cpu_addr),
    .rom_bank(rom_bank), .rom_offset(rom_offset), .rom_en(rom_en)
  );

  task automatic wr_bank(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bank_we = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    bank_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic exp_en,
                       input logic [7:0] exp_bank, input string req);
    cpu_addr = a;
    #1;
    checks++;
    if (rom_en !== exp_en || rom_bank !== exp_bank || rom_offset !== a[12:0]) begin
      fails++;
      $display("FAIL %s addr=%h: en=%b bank=%h off=%h expected en=%b bank=%h off=%h",
               req, a, rom_en, rom_bank, rom_offset, exp_en, exp_bank, a[12:0]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic t_reset();
    probe(16'h8000, 1'b1, 8'h3C, "R1");
    probe(16'hA000, 1'b1, 8'h3D, "R1");
    probe(16'hC000, 1'b1, 8'h3E, "R1");
    probe(16'hF234, 1'b1, 8'h3F, "R1 R9");
    probe(16'h6000, 1'b0, 8'h00, "R1 R8");
    probe(16'h0000, 1'b0, 8'h00, "R8");
    probe(16'h5FFF, 1'b0, 8'h00, "R8");
  endtask

  task automatic t_mode32();
    wr_ctrl(2'd3, 8'h00);
    wr_ctrl(2'd0, 8'h04);
    wr_bank(2'd3, 8'h07);
    probe(16'h8000, 1'b1, 8'h1C, "R3 R2");
    probe(16'hE000, 1'b1, 8'h1F, "R3");
    wr_bank(2'd3, 8'h35);
    probe(16'h8001, 1'b1, 8'h14, "R3 R10");
    probe(16'hBFFF, 1'b1, 8'h15, "R3");
  endtask

  task automatic t_mode16();
    wr_ctrl(2'd0, 8'h01);
    wr_bank(2'd1, 8'h2A);
    probe(16'h8000, 1'b1, 8'h14, "R4");
    probe(16'hA000, 1'b1, 8'h15, "R4");
    probe(16'hC000, 1'b1, 8'h3E, "R4");
    probe(16'hFFFF, 1'b1, 8'h3F, "R4 R9");
    wr_ctrl(2'd0, 8'h05);
    wr_bank(2'd3, 8'h26);
    probe(16'hC000, 1'b1, 8'h0C, "R4");
    probe(16'hE000, 1'b1, 8'h0D, "R4");
  endtask

  task automatic t_mode8();
    wr_bank(2'd0, 8'h41);
    wr_bank(2'd1, 8'h12);
    wr_bank(2'd2, 8'h20);
    wr_bank(2'd3, 8'h15);
    for (int code = 2; code <= 7; code++) begin
      if (code == 4) code = 6;
      wr_ctrl(2'd0, 8'(code));
      probe(16'h8000, 1'b1, 8'h01, "R5 R2");
      probe(16'hA000, 1'b1, 8'h12, "R5 R2");
      probe(16'hC000, 1'b1, 8'h20, "R5 R2");
      probe(16'hE000, 1'b1, (code >= 6) ? 8'h15 : 8'h3F, "R5");
    end
  endtask

  task automatic t_outer();
    wr_ctrl(2'd0, 8'h06);
    wr_ctrl(2'd3, 8'h06);
    probe(16'h8000, 1'b1, 8'hC1, "R6");
    probe(16'hE000, 1'b1, 8'hD5, "R6");
    wr_ctrl(2'd3, 8'h02);
    probe(16'h8000, 1'b1, 8'h41, "R6");
    wr_ctrl(2'd0, 8'h00);
    wr_ctrl(2'd3, 8'h04);
    probe(16'h8000, 1'b1, 8'hBC, "R6");
    probe(16'hE000, 1'b1, 8'hBF, "R6");
    wr_ctrl(2'd3, 8'hF9);
    probe(16'h8000, 1'b1, 8'h3C, "R6");
  endtask

  task automatic t_window();
    wr_ctrl(2'd3, 8'h00);
    wr_bank(2'd3, 8'h15);
    wr_ctrl(2'd0, 8'h80);
    probe(16'h7ABC, 1'b1, 8'h17, "R7 R9");
    probe(16'h8000, 1'b1, 8'h3C, "R7");
    probe(16'h5FFF, 1'b0, 8'h00, "R8");
    wr_ctrl(2'd0, 8'h81);
    probe(16'h6000, 1'b1, 8'h2B, "R7");
    wr_ctrl(2'd0, 8'h82);
    probe(16'h6000, 1'b1, 8'h15, "R7");
    wr_ctrl(2'd3, 8'h02);
    probe(16'h6000, 1'b1, 8'h55, "R7 R6");
    wr_ctrl(2'd3, 8'h00);
    wr_bank(2'd3, 8'hFF);
    wr_ctrl(2'd0, 8'h80);
    probe(16'h6000, 1'b1, 8'h3F, "R7");
    wr_ctrl(2'd0, 8'h85);
    probe(16'h7FFF, 1'b1, 8'h3F, "R7");
    wr_ctrl(2'd0, 8'h05);
    probe(16'h6000, 1'b0, 8'h00, "R7 R8");
  endtask

  task automatic t_ignored_ctrl();
    wr_ctrl(2'd3, 8'h00);
    wr_bank(2'd0, 8'h41);
    wr_ctrl(2'd0, 8'h02);
    wr_ctrl(2'd1, 8'h84);
    wr_ctrl(2'd2, 8'h87);
    probe(16'h6000, 1'b0, 8'h00, "R2");
    probe(16'h8000, 1'b1, 8'h01, "R2");
    probe(16'hE000, 1'b1, 8'h3F, "R2");
  endtask

  initial begin
    rst = 1'b1; bank_we = 1'b0; ctrl_we = 1'b0;
    wr_sel = '0; wr_data = '0; cpu_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mode32();
    t_mode16();
    t_mode8();
    t_outer();
    t_window();
    t_ignored_ctrl();
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below %0d",
               WATCHDOG, WATCHDOG);
      summary();
      $finish;
    end
  end

endmodule